// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: a line sync, a frame sync, a data-enable strobe, the column and row of the pixel currently being scanned, a pixel clock level, and a one-cycle frame interrupt. Every timing segment is a run-time input. Each axis runs through four segments in a fixed order: sync, back porch, active, front porch. The vertical axis advances once for each completed horizontal line.

The system clock is divided down to form the pixel clock. Each pixel period lasts a programmable number of system cycles. A global enable starts scanning from the first pixel of a frame. Dropping the enable lets the current frame finish before the block goes quiet. Sync, data-enable and pixel clock outputs each have their own inversion control. Timing fields are expected to stay stable while the block is scanning.

Two kinds of state machine drive the block.

- **Axis sequencer.** It has one state per segment: SYNC, BACK, ACT and FRONT. When the last count of a segment is stepped, it moves to the next segment in the order SYNC→BACK→ACT→FRONT→SYNC. It is forced back to SYNC while the block is idle.
- **Run controller.** Its states are IDLE, ACTIVE and DRAIN.
  - IDLE→ACTIVE when the enable is seen high.
  - ACTIVE→DRAIN when the enable is seen low before the end of the frame.
  - ACTIVE→IDLE when the enable is seen low on the last step of a frame.
  - DRAIN→ACTIVE when the enable returns.
  - DRAIN→IDLE on the last step of the frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: The line sync is active for `h_sync_m1`+1 pixels from the start of each line. The back porch (`h_back_m1`+1 pixels), the active region (`h_act_m1`+1 pixels) and the front porch (`h_front_m1`+1 pixels) follow, and then the next line begins.
- R2: The frame sync is active for `v_sync_m1`+1 lines from the start of each frame. The back porch (`v_back_m1`+1 lines), the active region (`v_act_m1`+1 lines) and the front porch (`v_front_m1`+1 lines) follow, all counted in whole lines.
- R3: Data-enable is active only when both axes are in their active regions. `pix_x` and `pix_y` give the zero-based position inside the horizontal and vertical active regions, and each reads 0 outside its own active region.
- R4: When set to 1, each of `inv_hs`, `inv_vs`, `inv_de` and `inv_pclk` inverts its output. With a value of 0, sync and data-enable are high when active.
- R5: With `div_direct`=1, a pixel lasts `div_m1`+1 system cycles. With `div_direct`=0, a pixel lasts one cycle and `div_m1` has no effect. The pixel clock level is high (before inversion) for the first ceil(ratio/2) cycles of each pixel, and it rests high while idle.
- R6: The divide ratio is clamped to 255: `div_m1`=255 gives 255 cycles per pixel.
- R7: When `irq_en`=1, `frame_irq` pulses for one cycle in the first cycle of every frame sync. It stays 0 when `irq_en`=0.
- R8: After reset the block is idle, with sync and data-enable inactive. The first cycle after the enable is seen high is pixel 0 of line 0. When the enable is seen low, scanning continues to the end of that frame and then stops with the outputs inactive.
- R9: If the enable returns before the frame ends, scanning continues without a restart or a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| video_en | input | 1 | Global scan enable |
| h_sync_m1 | input | H_CW | Line sync width minus one |
| h_back_m1 | input | H_CW | Horizontal back porch minus one |
| h_act_m1 | input | H_CW | Active pixels per line minus one |
| h_front_m1 | input | H_CW | Horizontal front porch minus one |
| v_sync_m1 | input | V_CW | Frame sync width in lines minus one |
| v_back_m1 | input | V_CW | Vertical back porch minus one |
| v_act_m1 | input | V_CW | Active lines minus one |
| v_front_m1 | input | V_CW | Vertical front porch minus one |
| inv_hs | input | 1 | Invert line sync |
| inv_vs | input | 1 | Invert frame sync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel clock level |
| div_direct | input | 1 | Use the divider field |
| div_m1 | input | DIV_W | Divide ratio minus one |
| irq_en | input | 1 | Enable frame interrupt |
| lcd_hsync | output | 1 | Line sync |
| lcd_vsync | output | 1 | Frame sync |
| lcd_de | output | 1 | Data-enable |
| lcd_pclk | output | 1 | Pixel clock level |
| pix_x | output | H_CW | Column within the active region |
| pix_y | output | V_CW | Row within the active region |
| frame_irq | output | 1 | Frame-start interrupt pulse |

## Verification
The bench builds the block with `H_CW`=6, `V_CW`=5 and `DIV_W`=8. The narrow counters make a whole frame only 77 pixels long (11 pixels by 7 lines), so several full frames, their wrap points and the frame-boundary interrupt all fit in a few hundred cycles. Single-line sync segments exercise a zero-valued field. Keeping the divider at its full 8 bits brings the 255 clamp, with its 128-cycle high phase, within reach.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    // Segment order along one axis; the sequence is behaviour.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } axis_phase_e;

    typedef enum logic [1:0] {
        RC_IDLE   = 2'd0,
        RC_ACTIVE = 2'd1,
        RC_DRAIN  = 2'd2
    } run_state_e;

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             direct_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             ce_o,
    output logic             lvl_o
);
    localparam logic [DIV_W-1:0] MAX_RATIO = '1;
    localparam logic [DIV_W-1:0] ONE       = DIV_W'(1);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] term;
    logic [DIV_W:0]   half;
    logic [DIV_W-1:0] dcnt_q;
    logic [DIV_W-1:0] dcnt_d;

    // Ratio selection: undivided unless the direct bit is set; clamp at max.
    always_comb begin
        if (!direct_i) begin
            ratio = ONE;
        end else if (div_m1_i == MAX_RATIO) begin
            ratio = MAX_RATIO;
        end else begin
            ratio = div_m1_i + ONE;
        end
        term = ratio - ONE;
        half = ({1'b0, ratio} + (DIV_W+1)'(1)) >> 1;
    end

    always_comb begin
        if (!run_i) begin
            dcnt_d = '0;
        end else if (dcnt_q == term) begin
            dcnt_d = '0;
        end else begin
            dcnt_d = dcnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else begin
            dcnt_q <= dcnt_d;
        end
    end

    always_comb begin
        ce_o  = run_i && (dcnt_q == term);
        lvl_o = ({1'b0, dcnt_q} < half);
    end

endmodule

// File: rtl/lcd_axis_seq.sv
module lcd_axis_seq
    import lcd_sync_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [CW-1:0] sync_m1_i,
    input  logic [CW-1:0] back_m1_i,
    input  logic [CW-1:0] act_m1_i,
    input  logic [CW-1:0] front_m1_i,
    output axis_phase_e   phase_o,
    output logic [CW-1:0] pos_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    axis_phase_e   ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] seg_m1;
    logic          seg_end;

    always_comb begin
        unique case (ph_q)
            PH_SYNC:  seg_m1 = sync_m1_i;
            PH_BACK:  seg_m1 = back_m1_i;
            PH_ACT:   seg_m1 = act_m1_i;
            PH_FRONT: seg_m1 = front_m1_i;
        endcase
        seg_end = (cnt_q == seg_m1);
    end

    // Next-state: advance the segment on its last step.
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        if (clear_i) begin
            ph_d  = PH_SYNC;
            cnt_d = '0;
        end else if (step_i) begin
            if (seg_end) begin
                cnt_d = '0;
                unique case (ph_q)
                    PH_SYNC:  ph_d = PH_BACK;
                    PH_BACK:  ph_d = PH_ACT;
                    PH_ACT:   ph_d = PH_FRONT;
                    PH_FRONT: ph_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        phase_o = ph_q;
        pos_o   = (ph_q == PH_ACT) ? cnt_q : '0;
        wrap_o  = step_i && !clear_i && (ph_q == PH_FRONT) && seg_end;
    end

endmodule

// File: rtl/lcd_run_ctl.sv
module lcd_run_ctl
    import lcd_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic video_en_i,
    input  logic frame_last_i,
    output logic running_o
);
    run_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RC_IDLE: begin
                if (video_en_i) st_d = RC_ACTIVE;
            end
            RC_ACTIVE: begin
                if (!video_en_i) st_d = frame_last_i ? RC_IDLE : RC_DRAIN;
            end
            RC_DRAIN: begin
                if (video_en_i)        st_d = RC_ACTIVE;
                else if (frame_last_i) st_d = RC_IDLE;
            end
            default: st_d = RC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        running_o = (st_q != RC_IDLE);
    end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int H_CW  = 12,
    parameter int V_CW  = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             video_en,
    input  logic [H_CW-1:0]  h_sync_m1,
    input  logic [H_CW-1:0]  h_back_m1,
    input  logic [H_CW-1:0]  h_act_m1,
    input  logic [H_CW-1:0]  h_front_m1,
    input  logic [V_CW-1:0]  v_sync_m1,
    input  logic [V_CW-1:0]  v_back_m1,
    input  logic [V_CW-1:0]  v_act_m1,
    input  logic [V_CW-1:0]  v_front_m1,
    input  logic             inv_hs,
    input  logic             inv_vs,
    input  logic             inv_de,
    input  logic             inv_pclk,
    input  logic             div_direct,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             irq_en,
    output logic             lcd_hsync,
    output logic             lcd_vsync,
    output logic             lcd_de,
    output logic             lcd_pclk,
    output logic [H_CW-1:0]  pix_x,
    output logic [V_CW-1:0]  pix_y,
    output logic             frame_irq
);
    logic          running_w;
    logic          pix_ce;
    logic          pclk_lvl;
    logic          axis_clear;
    logic          h_wrap;
    logic          v_wrap;
    axis_phase_e   h_ph;
    axis_phase_e   v_ph;
    logic [H_CW-1:0] h_pos;
    logic [V_CW-1:0] v_pos;
    logic          irq_q;

    assign axis_clear = !running_w;

    lcd_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running_w),
        .direct_i (div_direct),
        .div_m1_i (div_m1),
        .ce_o     (pix_ce),
        .lvl_o    (pclk_lvl)
    );

    lcd_axis_seq #(.CW(H_CW)) u_hax (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (axis_clear),
        .step_i     (pix_ce),
        .sync_m1_i  (h_sync_m1),
        .back_m1_i  (h_back_m1),
        .act_m1_i   (h_act_m1),
        .front_m1_i (h_front_m1),
        .phase_o    (h_ph),
        .pos_o      (h_pos),
        .wrap_o     (h_wrap)
    );

    lcd_axis_seq #(.CW(V_CW)) u_vax (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (axis_clear),
        .step_i     (h_wrap),
        .sync_m1_i  (v_sync_m1),
        .back_m1_i  (v_back_m1),
        .act_m1_i   (v_act_m1),
        .front_m1_i (v_front_m1),
        .phase_o    (v_ph),
        .pos_o      (v_pos),
        .wrap_o     (v_wrap)
    );

    lcd_run_ctl u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .video_en_i   (video_en),
        .frame_last_i (v_wrap),
        .running_o    (running_w)
    );

    // Frame interrupt: set on the edge where a new frame's sync begins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_en && video_en && (!running_w || v_wrap);
        end
    end

    always_comb begin
        lcd_hsync = inv_hs   ^ (running_w && (h_ph == PH_SYNC));
        lcd_vsync = inv_vs   ^ (running_w && (v_ph == PH_SYNC));
        lcd_de    = inv_de   ^ (running_w && (h_ph == PH_ACT) && (v_ph == PH_ACT));
        lcd_pclk  = inv_pclk ^ pclk_lvl;
        pix_x     = h_pos;
        pix_y     = v_pos;
        frame_irq = irq_q;
    end

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic video_en,
    input logic lcd_hsync,
    input logic lcd_vsync,
    input logic lcd_de,
    input logic inv_hs,
    input logic inv_vs,
    input logic inv_de,
    input logic div_direct,
    input logic frame_irq,
    input logic running,
    input logic pix_ce
);
    // R3
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_de ^ inv_de) |-> (!(lcd_hsync ^ inv_hs) && !(lcd_vsync ^ inv_vs)));

    // R7
    irq_in_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> (lcd_vsync ^ inv_vs));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!(lcd_hsync ^ inv_hs) && !(lcd_vsync ^ inv_vs) && !(lcd_de ^ inv_de)));

    // R8
    start_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && video_en) |=> running);

    // R5
    undivided_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !div_direct) |-> pix_ce);

endmodule

bind lcd_sync_gen lcd_sync_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .video_en   (video_en),
    .lcd_hsync  (lcd_hsync),
    .lcd_vsync  (lcd_vsync),
    .lcd_de     (lcd_de),
    .inv_hs     (inv_hs),
    .inv_vs     (inv_vs),
    .inv_de     (inv_de),
    .div_direct (div_direct),
    .frame_irq  (frame_irq),
    .running    (running_w),
    .pix_ce     (pix_ce)
);

// File: tb/lcd_sync_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb_top;
    localparam int H_CW  = 6;
    localparam int V_CW  = 5;
    localparam int DIV_W = 8;
    localparam int HSW = 2, HBP = 3, HACT = 4, HFP = 2;
    localparam int VSW = 1, VBP = 2, VACT = 3, VFP = 1;
    localparam int HT = HSW + HBP + HACT + HFP;
    localparam int VT = VSW + VBP + VACT + VFP;
    localparam int NEVER = 1 << 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic video_en = 1'b0;
    logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
    logic div_direct = 1'b0;
    logic [DIV_W-1:0] div_m1 = '0;
    logic irq_en = 1'b0;
    logic lcd_hsync, lcd_vsync, lcd_de, lcd_pclk, frame_irq;
    logic [H_CW-1:0] pix_x;
    logic [V_CW-1:0] pix_y;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    lcd_sync_gen #(.H_CW(H_CW), .V_CW(V_CW), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .video_en(video_en),
        .h_sync_m1(H_CW'(HSW-1)), .h_back_m1(H_CW'(HBP-1)),
        .h_act_m1(H_CW'(HACT-1)), .h_front_m1(H_CW'(HFP-1)),
        .v_sync_m1(V_CW'(VSW-1)), .v_back_m1(V_CW'(VBP-1)),
        .v_act_m1(V_CW'(VACT-1)), .v_front_m1(V_CW'(VFP-1)),
        .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .inv_pclk(inv_pclk),
        .div_direct(div_direct), .div_m1(div_m1), .irq_en(irq_en),
        .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
        .lcd_pclk(lcd_pclk), .pix_x(pix_x), .pix_y(pix_y), .frame_irq(frame_irq)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        video_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk);
        #2;
    endtask

    task automatic set_cfg(input logic inv, input logic direct, input int dm1, input logic ien);
        inv_hs = inv; inv_vs = inv; inv_de = inv; inv_pclk = inv;
        div_direct = direct;
        div_m1 = DIV_W'(dm1);
        irq_en = ien;
    endtask

    // Cycle-accurate expectation from the requirement arithmetic.
    task automatic run_scn(input string tag, input int n, input int cycles,
                           input int drop_t, input int raise_t);
        int f_cyc, stop_t, kf;
        f_cyc = n * HT * VT;
        stop_t = NEVER;
        if (drop_t >= 0) begin
            kf = ((drop_t / f_cyc) + 1) * f_cyc;
            if (!(raise_t > drop_t && raise_t < kf)) stop_t = kf;
        end
        video_en = 1'b1;
        @(posedge clk);
        #2;
        for (int t = 0; t < cycles; t++) begin
            bit act, hr, vr;
            int pix, hp, ln, ph;
            act = (t < stop_t);
            ph  = t % n;
            pix = t / n;
            hp  = pix % HT;
            ln  = (pix / HT) % VT;
            hr  = (hp >= HSW + HBP) && (hp < HSW + HBP + HACT);
            vr  = (ln >= VSW + VBP) && (ln < VSW + VBP + VACT);
            chk({tag, " R1 hsync"}, int'(lcd_hsync), int'(inv_hs ^ (act && hp < HSW)));
            chk({tag, " R2 vsync"}, int'(lcd_vsync), int'(inv_vs ^ (act && ln < VSW)));
            chk({tag, " R3 de"},    int'(lcd_de),    int'(inv_de ^ (act && hr && vr)));
            chk({tag, " R3 x"},     int'(pix_x),     (act && hr) ? hp - (HSW + HBP) : 0);
            chk({tag, " R3 y"},     int'(pix_y),     (act && vr) ? ln - (VSW + VBP) : 0);
            chk({tag, " R5 pclk"},  int'(lcd_pclk),  int'(inv_pclk ^ (act ? (ph < (n + 1) / 2) : 1'b1)));
            chk({tag, " R7 irq"},   int'(frame_irq), int'(irq_en && act && (t % f_cyc == 0)));
            if (t == drop_t)  video_en = 1'b0;
            if (t == raise_t) video_en = 1'b1;
            @(posedge clk);
            #2;
        end
    endtask

    task automatic t_reset_state();
        set_cfg(1'b0, 1'b0, 0, 1'b1);
        do_reset();
        chk("R8 reset hsync", int'(lcd_hsync), 0);
        chk("R8 reset vsync", int'(lcd_vsync), 0);
        chk("R8 reset de",    int'(lcd_de),    0);
        chk("R8 reset pclk",  int'(lcd_pclk),  1);
        chk("R8 reset irq",   int'(frame_irq), 0);
        chk("R8 reset x",     int'(pix_x),     0);
    endtask

    // Direct bit clear: div_m1 must be ignored (R5).
    task automatic t_basic_undivided();
        set_cfg(1'b0, 1'b0, 7, 1'b1);
        do_reset();
        run_scn("basic R5", 1, 2 * HT * VT + 5, -1, -1);
    endtask

    task automatic t_inverted_divided();
        set_cfg(1'b1, 1'b1, 2, 1'b0);
        do_reset();
        run_scn("invert R4", 3, HT * VT * 3 + 20, -1, -1);
    endtask

    task automatic t_stop_at_frame_end();
        set_cfg(1'b0, 1'b1, 1, 1'b1);
        do_reset();
        run_scn("stop R8", 2, 2 * HT * VT * 2 + 40, HT * VT * 2 + 10, -1);
    endtask

    task automatic t_resume_in_drain();
        set_cfg(1'b0, 1'b0, 0, 1'b1);
        do_reset();
        run_scn("resume R9", 1, 2 * HT * VT + 5, 5, 9);
    endtask

    task automatic t_ratio_clamp();
        set_cfg(1'b0, 1'b1, 255, 1'b1);
        do_reset();
        run_scn("clamp R6", 255, 255 * 4 + 10, -1, -1);
    endtask

    initial begin
        t_reset_state();
        t_basic_undivided();
        t_inverted_divided();
        t_stop_at_frame_end();
        t_resume_in_drain();
        t_ratio_clamp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule